// File: doc/BRIEF.md
# Block-Ack Send Window Tracker

This block follows one aggregation queue through a sliding window of at most 64 consecutive descriptor indices. The window begins at the queue's read index. For every position in the window it keeps two flags, one saying the descriptor has gone out and one saying the receiver has confirmed it, plus a resend mark. It offers the transmit path one index at a time over a valid/ready stream. The offer is either a descriptor that must go out again or the next fresh descriptor. A handshake on that stream counts as the send event for the offered index.

Block-ack reports come in over a second valid/ready stream. Each report carries a starting sequence number and a 64-bit bitmap. The low 8 bits of a sequence number are the descriptor index. Confirmations may arrive in any order. A transmitted entry that a report covers but does not confirm is marked for resending. The read index moves forward only across an unbroken run of confirmed entries at the front of the window. The window-size-left flag shows whether a fresh descriptor may still be requested under the configured window size.

Back-pressure rules: the offer (`nxt_valid`, `nxt_idx`, `nxt_resend`) stays unchanged while it waits on `nxt_ready`, unless a report is taken or a window load occurs in that cycle. A report is accepted only in a cycle without a send handshake, so `ba_ready` is low whenever `nxt_valid && nxt_ready`. A loading pulse on `init_valid` overrides both streams.

Top module: `ba_window_tracker`

## Requirements
- R1: After reset the read index is 0 and the window is empty. `nxt_resend` is 0, `nxt_idx` equals the read index, and `wsl` is 1 whenever the configured size is non-zero.
- R2: A cycle with `init_valid` high loads `init_idx` as the read index and empties the window. The new read index is visible on `rd_idx` from the next cycle.
- R3: Fresh indices are offered in order, read index plus the number of entries already in the window, modulo 256. Each send handshake with `nxt_resend`=0 adds one entry.
- R4: `wsl` is 1 exactly when the number of window entries is below min(`cfg_win_size`, 64). With no resend pending and `wsl`=0, `nxt_valid` is 0.
- R5: Bitmap bit i of a report refers to index (`ba_ssn` + i) mod 256. Such a bit confirms the entry only if that index is a transmitted entry of the current window. Bits for any other index have no effect.
- R6: A transmitted, unconfirmed entry that a report covers with a 0 bit is marked for resending. Marked entries are offered with `nxt_resend`=1, lowest window offset first, ahead of any fresh index. A later confirmation removes the mark.
- R7: One cycle after a report handshake, `rd_idx` has moved past all leading confirmed entries and `rd_adv` pulses for one cycle. If the first entry is unconfirmed, `rd_idx` stays put and `rd_adv` stays 0.
- R8: `ba_ready` is 0 in any cycle with a send handshake. A waiting offer keeps its index and kind unless a report or load is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_win_size | input | 7 | Configured window size (values above 64 act as 64) |
| init_valid | input | 1 | Load a new read index and empty the window |
| init_idx | input | 8 | Read index to load |
| nxt_valid | output | 1 | An index is offered for sending |
| nxt_ready | input | 1 | Transmit path takes the offer; handshake is the send event |
| nxt_idx | output | 8 | Offered descriptor index |
| nxt_resend | output | 1 | Offer is a resend of an unconfirmed entry |
| wsl | output | 1 | Window has room for a fresh descriptor |
| ba_valid | input | 1 | Block-ack report present |
| ba_ready | output | 1 | Report accepted this cycle |
| ba_ssn | input | 12 | Starting sequence number of the report |
| ba_bitmap | input | 64 | Confirmation bits, bit i for sequence ssn+i |
| rd_idx | output | 8 | Current read index (window base) |
| rd_adv | output | 1 | One-cycle pulse when the read index moved |

## Verification
The offer outputs and `wsl` are combinational from the stored window, so the consequences of a send or report handshake show up in the cycle right after that clock edge. `rd_idx` and `rd_adv` reflect a report one cycle after its handshake edge. The bench drives inputs after a rising edge and samples everything on the falling edge. A scoreboard queue holds the expected index and kind of every send. The monitor pops it at each handshake seen on a falling edge. Read-index, flag and stall checks are sampled on the first falling edge after the triggering handshake.

// File: rtl/ba_pkg.sv
package ba_pkg;
  // Descriptor index width: an index is the sequence number modulo 256.
  localparam int unsigned IDX_W = 8;

  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic {
    OFFER_FRESH  = 1'b0,
    OFFER_RESEND = 1'b1
  } offer_kind_e;
endpackage

// File: rtl/ba_cover.sv
// Maps each window offset onto a report bitmap position.
module ba_cover
  import ba_pkg::*;
#(
  parameter int unsigned WIN   = 64,
  parameter int unsigned SSN_W = 12
) (
  input  idx_t             base,
  input  logic [SSN_W-1:0] ssn,
  input  logic [WIN-1:0]   bitmap,
  output logic [WIN-1:0]   cov,
  output logic [WIN-1:0]   hit
);
  localparam int unsigned OFS_W = $clog2(WIN);

  idx_t ssn_idx;
  assign ssn_idx = ssn[IDX_W-1:0];

  for (genvar j = 0; j < WIN; j++) begin : g_ofs
    idx_t rel;
    assign rel    = base + idx_t'(j) - ssn_idx;
    assign cov[j] = (32'(rel) < WIN);
    assign hit[j] = cov[j] & bitmap[rel[OFS_W-1:0]];
  end
endmodule

// File: rtl/ba_first_set.sv
// Lowest set position of a vector.
module ba_first_set #(
  parameter int unsigned WIN = 64
) (
  input  logic [WIN-1:0]         vec,
  output logic                   found,
  output logic [$clog2(WIN)-1:0] pos
);
  localparam int unsigned OFS_W = $clog2(WIN);

  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = WIN - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        pos   = OFS_W'(i);
      end
    end
  end
endmodule

// File: rtl/ba_lead_ones.sv
// Length of the unbroken run of ones starting at bit 0.
module ba_lead_ones #(
  parameter int unsigned WIN = 64
) (
  input  logic [WIN-1:0]           vec,
  output logic [$clog2(WIN):0]     run
);
  localparam int unsigned CNT_W = $clog2(WIN) + 1;

  always_comb begin
    logic going;
    going = 1'b1;
    run   = '0;
    for (int i = 0; i < WIN; i++) begin
      going = going & vec[i];
      if (going) run = CNT_W'(i + 1);
    end
  end
endmodule

// File: rtl/ba_window_tracker.sv
module ba_window_tracker
  import ba_pkg::*;
#(
  parameter int unsigned WIN_MAX = 64,
  parameter int unsigned CFG_W   = 7,
  parameter int unsigned SSN_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CFG_W-1:0]   cfg_win_size,
  input  logic               init_valid,
  input  logic [IDX_W-1:0]   init_idx,
  output logic               nxt_valid,
  input  logic               nxt_ready,
  output logic [IDX_W-1:0]   nxt_idx,
  output logic               nxt_resend,
  output logic               wsl,
  input  logic               ba_valid,
  output logic               ba_ready,
  input  logic [SSN_W-1:0]   ba_ssn,
  input  logic [WIN_MAX-1:0] ba_bitmap,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               rd_adv
);
  localparam int unsigned OFS_W = $clog2(WIN_MAX);
  localparam int unsigned CNT_W = OFS_W + 1;

  idx_t               base_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WIN_MAX-1:0] sent_q, ack_q, rs_q;
  logic               adv_q;

  logic [CNT_W-1:0]   eff_win;
  logic               rs_any;
  logic [OFS_W-1:0]   rs_ofs;
  logic               send_hs, ba_hs;
  logic [WIN_MAX-1:0] cov, hit, ack_mid, rs_mid;
  logic [CNT_W-1:0]   lead_n;
  offer_kind_e        kind;

  assign eff_win = (32'(cfg_win_size) > WIN_MAX) ? CNT_W'(WIN_MAX)
                                                 : CNT_W'(cfg_win_size);

  ba_first_set #(.WIN(WIN_MAX)) u_pick (
    .vec   (rs_q),
    .found (rs_any),
    .pos   (rs_ofs)
  );

  assign kind       = rs_any ? OFFER_RESEND : OFFER_FRESH;
  assign wsl        = (cnt_q < eff_win);
  assign nxt_valid  = rs_any | wsl;
  assign nxt_resend = (kind == OFFER_RESEND);
  assign nxt_idx    = base_q + (rs_any ? idx_t'(rs_ofs) : idx_t'(cnt_q));

  assign send_hs  = nxt_valid & nxt_ready;
  assign ba_ready = ~send_hs;
  assign ba_hs    = ba_valid & ba_ready;

  ba_cover #(.WIN(WIN_MAX), .SSN_W(SSN_W)) u_cover (
    .base   (base_q),
    .ssn    (ba_ssn),
    .bitmap (ba_bitmap),
    .cov    (cov),
    .hit    (hit)
  );

  assign ack_mid = ack_q | (sent_q & hit);
  assign rs_mid  = (rs_q | (sent_q & cov & ~hit)) & ~ack_mid;

  ba_lead_ones #(.WIN(WIN_MAX)) u_lead (
    .vec (ack_mid),
    .run (lead_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      sent_q <= '0;
      ack_q  <= '0;
      rs_q   <= '0;
      adv_q  <= 1'b0;
    end else if (init_valid) begin
      base_q <= init_idx;
      cnt_q  <= '0;
      sent_q <= '0;
      ack_q  <= '0;
      rs_q   <= '0;
      adv_q  <= 1'b0;
    end else if (ba_hs) begin
      sent_q <= sent_q >> lead_n;
      ack_q  <= ack_mid >> lead_n;
      rs_q   <= rs_mid >> lead_n;
      base_q <= base_q + idx_t'(lead_n);
      cnt_q  <= cnt_q - lead_n;
      adv_q  <= (lead_n != '0);
    end else begin
      adv_q <= 1'b0;
      if (send_hs) begin
        if (rs_any) begin
          rs_q[rs_ofs] <= 1'b0;
        end else begin
          sent_q[cnt_q[OFS_W-1:0]] <= 1'b1;
          cnt_q                    <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rd_idx = base_q;
  assign rd_adv = adv_q;
endmodule

// File: rtl/ba_window_tracker_chk.sv
module ba_window_tracker_chk #(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_valid,
  input logic             nxt_valid,
  input logic             nxt_ready,
  input logic [IDX_W-1:0] nxt_idx,
  input logic             nxt_resend,
  input logic             wsl,
  input logic             ba_valid,
  input logic             ba_ready,
  input logic [IDX_W-1:0] rd_idx,
  input logic             rd_adv
);
  // R4: a fresh offer needs room in the window
  p_fresh_needs_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_valid && !nxt_resend) |-> wsl);

  // R8: reports are refused during a send handshake
  p_no_ba_on_send_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_valid && nxt_ready) |-> !ba_ready);

  // R8: a waiting offer holds
  p_offer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_valid && !nxt_ready && !(ba_valid && ba_ready) && !init_valid)
      |=> (nxt_valid && $stable(nxt_idx) && $stable(nxt_resend)));

  // R7: the advance pulse only follows a taken report
  p_adv_after_ba_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv |-> $past(ba_valid && ba_ready && !init_valid));

  // R7: the read index only moves on a pulse or a load
  p_rd_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx != $past(rd_idx)) |-> (rd_adv || $past(init_valid)));
endmodule

bind ba_window_tracker ba_window_tracker_chk #(.IDX_W(ba_pkg::IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_valid (init_valid),
  .nxt_valid  (nxt_valid),
  .nxt_ready  (nxt_ready),
  .nxt_idx    (nxt_idx),
  .nxt_resend (nxt_resend),
  .wsl        (wsl),
  .ba_valid   (ba_valid),
  .ba_ready   (ba_ready),
  .rd_idx     (rd_idx),
  .rd_adv     (rd_adv)
);

// File: tb/ba_window_tracker_tb.sv
module ba_window_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  cfg_win_size;
  logic        init_valid;
  logic [7:0]  init_idx;
  logic        nxt_valid, nxt_ready, nxt_resend, wsl;
  logic [7:0]  nxt_idx;
  logic        ba_valid, ba_ready;
  logic [11:0] ba_ssn;
  logic [63:0] ba_bitmap;
  logic [7:0]  rd_idx;
  logic        rd_adv;

  int checks = 0;
  int fails  = 0;
  int hs_cnt = 0;
  logic [8:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ba_window_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_win_size(cfg_win_size),
    .init_valid(init_valid), .init_idx(init_idx),
    .nxt_valid(nxt_valid), .nxt_ready(nxt_ready), .nxt_idx(nxt_idx),
    .nxt_resend(nxt_resend), .wsl(wsl),
    .ba_valid(ba_valid), .ba_ready(ba_ready), .ba_ssn(ba_ssn),
    .ba_bitmap(ba_bitmap), .rd_idx(rd_idx), .rd_adv(rd_adv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: every send handshake pops one expected {resend, idx}.
  always @(negedge clk) begin
    if (rst_n && nxt_valid && nxt_ready) begin
      logic [8:0] got;
      got = {nxt_resend, nxt_idx};
      hs_cnt++;
      chk(ba_ready == 1'b0, "R8 ba_ready during send", int'(ba_ready), 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3/R6 unexpected send", int'(got), -1);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(got == e, "R3/R6 send {resend,idx}", int'(got), int'(e));
      end
    end
  end

  task automatic expect_send(input bit rs, input int idx);
    exp_q.push_back({rs, 8'(idx)});
  endtask

  task automatic drain(input int n);
    int target;
    target = hs_cnt + n;
    @(negedge clk);
    nxt_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      if (hs_cnt >= target) break;
    end
    nxt_ready = 1'b0;
  endtask

  task automatic send_ba(input int ssn, input logic [63:0] bm);
    @(negedge clk);
    ba_valid  = 1'b1;
    ba_ssn    = 12'(ssn);
    ba_bitmap = bm;
    @(posedge clk);
    #1;
    ba_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < WATCHDOG) begin
      @(posedge clk);
      wd++;
    end
    chk(1'b0, "watchdog", wd, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_win_size = 7'd4; init_valid = 1'b0; init_idx = '0;
    nxt_ready = 1'b0; ba_valid = 1'b0; ba_ssn = '0; ba_bitmap = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_idx == 8'd0, "R1 rd_idx", rd_idx, 0);
    chk(nxt_valid && !nxt_resend && nxt_idx == 8'd0, "R1 offer", nxt_idx, 0);
    chk(wsl == 1'b1, "R1 wsl", wsl, 1);

    // R2 load 250
    init_valid = 1'b1; init_idx = 8'd250;
    @(posedge clk); #1 init_valid = 1'b0;
    @(negedge clk);
    chk(rd_idx == 8'd250, "R2 rd_idx", rd_idx, 250);
    chk(nxt_idx == 8'd250 && !nxt_resend, "R2 offer", nxt_idx, 250);

    // R3 fresh sends, window of 4
    for (int i = 0; i < 4; i++) expect_send(1'b0, 250 + i);
    drain(4);
    @(negedge clk);
    chk(wsl == 1'b0, "R4 window full wsl", wsl, 0);
    chk(nxt_valid == 1'b0, "R4 no offer when full", nxt_valid, 0);

    // R5/R6: ssn 251 confirms 251,253; bit 10 (index 5) not transmitted
    send_ba(251, 64'h405);
    chk(rd_idx == 8'd250 && rd_adv == 1'b0, "R7 no advance", rd_idx, 250);
    chk(nxt_valid && nxt_resend && nxt_idx == 8'd252, "R6 resend offer", nxt_idx, 252);
    @(negedge clk);
    chk(nxt_idx == 8'd252 && nxt_resend, "R8 offer held", nxt_idx, 252);
    expect_send(1'b1, 252);
    drain(1);
    @(negedge clk);
    chk(nxt_valid == 1'b0, "R5 out-of-window bit ignored", nxt_valid, 0);

    // R7: confirm 250 and 252 -> base moves by 4
    send_ba(250, 64'h5);
    chk(rd_idx == 8'd254, "R7 rd_idx advance", rd_idx, 254);
    chk(rd_adv == 1'b1, "R7 rd_adv pulse", rd_adv, 1);
    @(negedge clk);
    chk(rd_adv == 1'b0, "R7 pulse one cycle", rd_adv, 0);

    // R3 wrap
    expect_send(1'b0, 254); expect_send(1'b0, 255);
    expect_send(1'b0, 0);   expect_send(1'b0, 1);
    drain(4);

    // R6 resends come before fresh ones
    cfg_win_size = 7'd8;
    send_ba(254, 64'h0);
    expect_send(1'b1, 254); expect_send(1'b1, 255);
    expect_send(1'b1, 0);   expect_send(1'b1, 1);
    for (int i = 2; i < 6; i++) expect_send(1'b0, i);
    drain(8);
    @(negedge clk);
    chk(wsl == 1'b0, "R4 wsl at size 8", wsl, 0);

    // Confirm 0,1 only: head 254 unconfirmed -> no advance, 2..5 marked
    send_ba(0, 64'h3);
    chk(rd_idx == 8'd254 && rd_adv == 1'b0, "R7 blocked head", rd_idx, 254);
    expect_send(1'b1, 2);
    drain(1);

    // Confirm all 8: marks on 3..5 dropped, base 6
    send_ba(254, 64'hFF);
    chk(rd_idx == 8'd6, "R7 advance over wrap", rd_idx, 6);
    chk(nxt_valid && !nxt_resend && nxt_idx == 8'd6, "R6 marks cleared", nxt_idx, 6);
    expect_send(1'b0, 6);
    drain(1);

    // R4 size 0 blocks fresh offers; R2 reload empties window
    cfg_win_size = 7'd0;
    init_valid = 1'b1; init_idx = 8'd100;
    @(posedge clk); #1 init_valid = 1'b0;
    @(negedge clk);
    chk(rd_idx == 8'd100, "R2 reload rd_idx", rd_idx, 100);
    chk(wsl == 1'b0 && nxt_valid == 1'b0, "R4 size zero", wsl, 0);
    cfg_win_size = 7'd100;
    @(negedge clk);
    chk(wsl == 1'b1 && nxt_idx == 8'd100, "R4 oversize acts as 64", wsl, 1);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected sends seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule